// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block collects maskable interrupt requests from on-chip timers, two DMA engines, nine dedicated external pins, eight programmable I/O pins and ten other on-chip peripherals. It groups them onto fifteen priority channels and raises a single request line to the processor. On acknowledge, it latches an interrupt type number that identifies the winning source.

Each channel has an in-service flag. While a channel is being serviced, that channel and every channel of lower priority are held off. Only a channel of strictly higher priority can interrupt the running handler. Software closes a handler by writing the type it was given into the end-of-interrupt register. That frees the channel and reopens the lower ones.

Three channels are shared:
- The timer channel reports a distinct type per timer.
- One channel is switched between the DMA engines and external pin 4.
- The last channel ORs fifteen pin sources through a mask register and reports one common type.

Top module: `nic_top`

## Requirements
- R1: After reset the request output is low, the type output is 0x00, no channel is in service, all fifteen shared-channel source masks are set, and channel 9 takes its request from external pin 4.
- R2: Priority is fixed by channel number, channel 0 highest. The presented channel is the lowest-numbered channel whose request is active, whose channel mask bit is clear, and that is not blocked by an in-service flag.
- R3: Register address 0 holds the channel mask (bit c masks channel c, reset 0). A masked channel's request has no effect on the output.
- R4: The request output is high only while the global interrupt-enable input is high.
- R5: An acknowledge pulse while the request output is high sets the presented channel's in-service flag. From the next cycle the type output holds that channel's type. An acknowledge while the request output is low changes nothing.
- R6: While channel k is in service, requests on channels k..14 are not presented, and requests on channels below k are.
- R7: Writing a type value to register address 3 clears the in-service flag of the channel that type decodes to. The channel and the lower ones can then be presented again.
- R8: An end-of-interrupt write whose type decodes to no channel, or to a channel not in service, leaves every in-service flag unchanged.
- R9: Channel 0 carries timers 0..2 with types 0x08+k. When several timers request at once, the lowest-numbered timer wins.
- R10: Register address 2 bit 0 selects channel 9's source: 0 for external pin 4 (type 0x29), 1 for the DMA engines (type 0x30+e, lowest-numbered engine wins). Types 0x29, 0x30 and 0x31 all decode to channel 9.
- R11: Channel 14 requests when any unmasked shared source is active, and its type is 0x2E. The shared mask is register address 1. Bits 7..0 mask programmable I/O pins 7..0, and bit 7+p masks external pin p for p = 1..7.
- R12: Channel 1 is external pin 0 and channel 2 is external pin 8. Channels 3..8 are peripheral requests 0..5, and channels 10..13 are peripheral requests 6..9. A plain channel c reports type 0x20+c.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ien_i | input | 1 | Global interrupt enable from the processor flags |
| timer_req_i | input | 3 | Timer level requests |
| dma_req_i | input | 2 | DMA engine level requests |
| ext_req_i | input | 9 | External interrupt pin levels 0..8 |
| pio_req_i | input | 8 | Programmable I/O interrupt levels |
| periph_req_i | input | 10 | Other on-chip peripheral requests |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address (0 channel mask, 1 shared mask, 2 channel 9 select, 3 end of interrupt) |
| wr_data_i | input | 15 | Write data (end-of-interrupt type in bits 7..0) |
| inta_i | input | 1 | Interrupt acknowledge pulse |
| intr_o | output | 1 | Interrupt request to the processor |
| int_type_o | output | 8 | Type of the last acknowledged interrupt |

## Verification
Directed sequences cover these cases:
- Several timers requesting together, which tells the in-channel order apart from the channel order.
- A serviced middle channel, first with only lower-priority traffic and then with a higher one, which separates blocking from pre-emption.
- A bogus end-of-interrupt between them, which shows that a wrong type leaves the nesting intact.
- Channel 9 flipped between its two sources, and channel 14 unmasked one source at a time, which tells the source multiplexing apart from the shared OR.

A long sparse random run then mixes level requests, enables, acknowledges, mask writes and end-of-interrupt writes. A bench model predicts the request line and the latched type in every cycle.

// File: rtl/nic_pkg.sv
// Shared constants, register addresses and the end-of-interrupt type decode.
// Assumes type values are 8 bits and channel numbers fit in 4 bits.
package nic_pkg;
    localparam int NCH  = 15;
    localparam int CHW  = 4;
    localparam int TW   = 8;
    localparam int NTMR = 3;
    localparam int NDMA = 2;
    localparam int NPIO = 8;
    localparam int NEXT = 9;
    localparam int NPER = 10;

    localparam int CH_TMR = 0;
    localparam int CH_MUX = 9;
    localparam int CH_SHR = 14;

    localparam logic [TW-1:0] T_TMR_BASE = 8'h08;
    localparam logic [TW-1:0] T_CH_BASE  = 8'h20;
    localparam logic [TW-1:0] T_DMA_BASE = 8'h30;

    typedef enum logic [1:0] {
        A_CHMASK = 2'd0,
        A_SHMASK = 2'd1,
        A_MUXSEL = 2'd2,
        A_EOI    = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic           hit;
        logic [CHW-1:0] ch;
    } eoi_dec_t;

    // Map a type value to its channel; hit is low when no channel owns it.
    function automatic eoi_dec_t eoi_decode(input logic [TW-1:0] t);
        eoi_dec_t   d;
        logic [TW-1:0] off;
        d.hit = 1'b0;
        d.ch  = '0;
        off   = t - T_CH_BASE;
        if (t >= T_TMR_BASE && t < T_TMR_BASE + TW'(NTMR)) begin
            d.hit = 1'b1;
            d.ch  = CHW'(CH_TMR);
        end else if (t > T_CH_BASE && t < T_CH_BASE + TW'(NCH)) begin
            d.hit = 1'b1;
            d.ch  = off[CHW-1:0];
        end else if (t >= T_DMA_BASE && t < T_DMA_BASE + TW'(NDMA)) begin
            d.hit = 1'b1;
            d.ch  = CHW'(CH_MUX);
        end
        return d;
    endfunction
endpackage

// File: rtl/nic_regs.sv
// Software-visible control registers: channel mask, shared-source mask,
// channel 9 source select, plus decode of end-of-interrupt writes.
// Assumes single-cycle write strobes.
module nic_regs
    import nic_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [1:0]     wr_addr,
    input  logic [NCH-1:0] wr_data,
    output logic [NCH-1:0] chmask,
    output logic [NCH-1:0] shmask,
    output logic           mux_dma,
    output logic           eoi_hit,
    output logic [CHW-1:0] eoi_ch
);
    eoi_dec_t dec;

    // Hold the mask and select registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chmask  <= '0;
            shmask  <= '1;
            mux_dma <= 1'b0;
        end else if (wr_en) begin
            case (reg_addr_e'(wr_addr))
                A_CHMASK: chmask  <= wr_data;
                A_SHMASK: shmask  <= wr_data;
                A_MUXSEL: mux_dma <= wr_data[0];
                default:  ;
            endcase
        end
    end

    // Turn an end-of-interrupt write into a channel clear request.
    always_comb begin
        dec     = eoi_decode(wr_data[TW-1:0]);
        eoi_hit = wr_en && (reg_addr_e'(wr_addr) == A_EOI) && dec.hit;
        eoi_ch  = dec.ch;
    end

    // R11
    shmask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd1) |=> (shmask == $past(wr_data)));
endmodule

// File: rtl/nic_inservice.sv
// One in-service flag per channel: set on acknowledge, cleared by a
// decoded end-of-interrupt. A set and a clear in the same cycle both apply.
module nic_inservice
    import nic_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           set_en,
    input  logic [CHW-1:0] set_ch,
    input  logic           clr_en,
    input  logic [CHW-1:0] clr_ch,
    output logic [NCH-1:0] is_q
);
    logic [NCH-1:0] set_v, clr_v;

    // Expand the set and clear channel numbers to vectors.
    always_comb begin
        set_v = '0;
        clr_v = '0;
        if (set_en) set_v[set_ch] = 1'b1;
        if (clr_en) clr_v[clr_ch] = 1'b1;
    end

    // Update the in-service flags.
    always_ff @(posedge clk) begin
        if (!rst_n) is_q <= '0;
        else        is_q <= (is_q & ~clr_v) | set_v;
    end

    // R5
    set_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> is_q[$past(set_ch)]);
    // R7
    eoi_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && is_q[clr_ch] && !(set_en && set_ch == clr_ch)) |=> !is_q[$past(clr_ch)]);
    // R8
    stray_eoi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !is_q[clr_ch] && !set_en) |=> $stable(is_q));
endmodule

// File: rtl/nic_arbiter.sv
// Maps sources onto channels, applies masks and in-service blocking, and
// picks the highest-priority (lowest-numbered) eligible channel and its type.
// Purely combinational; clk/rst_n are used only by the checks.
module nic_arbiter
    import nic_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NTMR-1:0] tmr,
    input  logic [NDMA-1:0] dma,
    input  logic [NEXT-1:0] ext,
    input  logic [NPIO-1:0] pio,
    input  logic [NPER-1:0] per,
    input  logic [NCH-1:0]  chmask,
    input  logic [NCH-1:0]  shmask,
    input  logic            mux_dma,
    input  logic [NCH-1:0]  is_q,
    output logic            found,
    output logic [CHW-1:0]  win_ch,
    output logic [TW-1:0]   win_type
);
    localparam int NSH = NPIO + 7;

    logic [NCH-1:0] raw, elig;
    logic [NSH-1:0] sh_src;
    logic           acc;

    // Gather each channel's raw request from its sources.
    always_comb begin
        sh_src = {ext[7:1], pio};
        raw    = '0;
        raw[CH_TMR] = |tmr;
        raw[1]      = ext[0];
        raw[2]      = ext[8];
        for (int k = 0; k < 6; k++) raw[3 + k] = per[k];
        raw[CH_MUX] = mux_dma ? |dma : ext[4];
        for (int k = 0; k < 4; k++) raw[10 + k] = per[6 + k];
        raw[CH_SHR] = |(sh_src & ~shmask);
    end

    // Block a channel when it or any higher-priority channel is in service.
    always_comb begin
        acc = 1'b0;
        for (int c = 0; c < NCH; c++) begin
            acc     = acc | is_q[c];
            elig[c] = raw[c] & ~chmask[c] & ~acc;
        end
    end

    // Select the lowest-numbered eligible channel.
    always_comb begin
        found  = 1'b0;
        win_ch = '0;
        for (int c = NCH - 1; c >= 0; c--) begin
            if (elig[c]) begin
                found  = 1'b1;
                win_ch = CHW'(c);
            end
        end
    end

    // Form the type of the winning channel and source.
    always_comb begin
        win_type = T_CH_BASE + TW'(win_ch);
        if (win_ch == CHW'(CH_TMR)) begin
            win_type = T_TMR_BASE;
            for (int k = NTMR - 1; k >= 0; k--)
                if (tmr[k]) win_type = T_TMR_BASE + TW'(k);
        end else if (win_ch == CHW'(CH_MUX) && mux_dma) begin
            win_type = T_DMA_BASE;
            for (int k = NDMA - 1; k >= 0; k--)
                if (dma[k]) win_type = T_DMA_BASE + TW'(k);
        end
    end

    // R3
    masked_never_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> !chmask[win_ch]);
    // R6
    not_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> !is_q[win_ch]);
    // R11
    shared_has_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (found && win_ch == CHW'(CH_SHR)) |-> ((sh_src & ~shmask) != '0));
endmodule

// File: rtl/nic_top.sv
// Nested priority interrupt controller top: registers, arbiter and
// in-service flags; gates the request with the global enable and latches
// the type on acknowledge. Assumes inta_i is a one-cycle pulse.
module nic_top
    import nic_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ien_i,
    input  logic [2:0]  timer_req_i,
    input  logic [1:0]  dma_req_i,
    input  logic [8:0]  ext_req_i,
    input  logic [7:0]  pio_req_i,
    input  logic [9:0]  periph_req_i,
    input  logic        wr_en_i,
    input  logic [1:0]  wr_addr_i,
    input  logic [14:0] wr_data_i,
    input  logic        inta_i,
    output logic        intr_o,
    output logic [7:0]  int_type_o
);
    logic [NCH-1:0] chmask, shmask, is_q;
    logic           mux_dma, eoi_hit, found, take;
    logic [CHW-1:0] eoi_ch, win_ch;
    logic [TW-1:0]  win_type;

    nic_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en_i), .wr_addr(wr_addr_i),
        .wr_data(wr_data_i), .chmask(chmask), .shmask(shmask),
        .mux_dma(mux_dma), .eoi_hit(eoi_hit), .eoi_ch(eoi_ch)
    );

    nic_arbiter u_arb (
        .clk(clk), .rst_n(rst_n), .tmr(timer_req_i), .dma(dma_req_i),
        .ext(ext_req_i), .pio(pio_req_i), .per(periph_req_i),
        .chmask(chmask), .shmask(shmask), .mux_dma(mux_dma), .is_q(is_q),
        .found(found), .win_ch(win_ch), .win_type(win_type)
    );

    nic_inservice u_is (
        .clk(clk), .rst_n(rst_n), .set_en(take), .set_ch(win_ch),
        .clr_en(eoi_hit), .clr_ch(eoi_ch), .is_q(is_q)
    );

    // Gate the request and qualify the acknowledge.
    always_comb begin
        intr_o = ien_i & found;
        take   = inta_i & intr_o;
    end

    // Latch the type of the acknowledged interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n)    int_type_o <= '0;
        else if (take) int_type_o <= win_type;
    end

    // R4
    enable_gates_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ien_i |-> !intr_o);
    // R5
    type_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (int_type_o == $past(win_type)));
    // R5
    idle_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inta_i && !intr_o) |=> $stable(int_type_o));
endmodule

// File: tb/sim_nic_top.sv
`timescale 1ns/1ps
module sim_nic_top;
    logic        clk = 1'b0, rst_n = 1'b0, ien = 1'b0;
    logic [2:0]  tmr = '0;
    logic [1:0]  dma = '0;
    logic [8:0]  ext = '0;
    logic [7:0]  pio = '0;
    logic [9:0]  per = '0;
    logic        wr_en = 1'b0, inta = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [14:0] wr_data = '0;
    logic        intr;
    logic [7:0]  itype;

    int checks = 0, fails = 0;
    string tag = "R1";

    logic [14:0] m_is = '0, m_chm = '0, m_shm = '1;
    logic        m_sel = 1'b0;
    logic [7:0]  m_type = '0;
    logic [7:0]  m_ty [15];

    always #2.5 clk = ~clk;

    nic_top u0 (
        .clk(clk), .rst_n(rst_n), .ien_i(ien), .timer_req_i(tmr),
        .dma_req_i(dma), .ext_req_i(ext), .pio_req_i(pio),
        .periph_req_i(per), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .inta_i(inta), .intr_o(intr),
        .int_type_o(itype)
    );

    task automatic check(input logic ok, input string t, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", t, act, exp, $time);
        end
    endtask

    // Channel owning a type value, per R7/R9/R10/R12; -1 when none.
    function automatic int type_ch(input logic [7:0] t);
        if (t >= 8'h08 && t <= 8'h0A) return 0;
        if (t >= 8'h21 && t <= 8'h2E) return int'(t) - 32;
        if (t == 8'h30 || t == 8'h31) return 9;
        return -1;
    endfunction

    // Expected winner per R2, R3, R6, R9..R12.
    task automatic model_win(output logic fnd, output int ch, output logic [7:0] ty);
        logic [14:0] raw;
        logic blk;
        raw = '0;
        raw[0] = |tmr; raw[1] = ext[0]; raw[2] = ext[8];
        for (int k = 0; k < 6; k++) raw[3+k] = per[k];
        raw[9] = m_sel ? |dma : ext[4];
        for (int k = 0; k < 4; k++) raw[10+k] = per[6+k];
        raw[14] = |({ext[7:1], pio} & ~m_shm);
        fnd = 1'b0; ch = 0; blk = 1'b0;
        for (int c = 0; c < 15; c++) begin
            blk = blk | m_is[c];
            if (!fnd && raw[c] && !m_chm[c] && !blk) begin
                fnd = 1'b1; ch = c;
            end
        end
        ty = 8'h20 + 8'(ch);
        if (ch == 0) ty = tmr[0] ? 8'h08 : (tmr[1] ? 8'h09 : 8'h0A);
        if (ch == 9 && m_sel) ty = dma[0] ? 8'h30 : 8'h31;
    endtask

    // One cycle: inputs already driven after a negedge.
    task automatic step();
        logic fnd, exp_i, tk;
        int ch, ec;
        logic [7:0] ty;
        logic [14:0] nis;
        #1;
        model_win(fnd, ch, ty);
        exp_i = ien & fnd;
        check(intr === exp_i, tag, int'(intr), int'(exp_i));
        tk  = inta & exp_i;
        nis = m_is;
        if (wr_en && wr_addr == 2'd3) begin
            ec = type_ch(wr_data[7:0]);
            if (ec >= 0) nis[ec] = 1'b0;
        end
        if (tk) nis[ch] = 1'b1;
        @(posedge clk);
        #1;
        m_is = nis;
        if (tk) begin m_type = ty; m_ty[ch] = ty; end
        if (wr_en && wr_addr == 2'd0) m_chm = wr_data;
        if (wr_en && wr_addr == 2'd1) m_shm = wr_data;
        if (wr_en && wr_addr == 2'd2) m_sel = wr_data[0];
        check(itype === m_type, tk ? tag : "R5", int'(itype), int'(m_type));
        wr_en = 1'b0; inta = 1'b0;
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [14:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d; step();
    endtask

    task automatic quiet();
        tmr = '0; dma = '0; ext = '0; pio = '0; per = '0;
    endtask

    initial begin
        for (int c = 0; c < 15; c++) m_ty[c] = 8'h00;
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state at the ports
        check(intr === 1'b0, "R1", int'(intr), 0);
        check(itype === 8'h00, "R1", int'(itype), 0);
        rst_n = 1'b1;
        ien = 1'b1;
        tag = "R1"; pio = 8'hFF; ext = 9'h0EE; step();       // all shared masked
        quiet(); ext[4] = 1'b1; inta = 1'b1; step();          // ch9 from pin 4
        check(itype === 8'h29, "R1", int'(itype), 8'h29);
        tag = "R7"; quiet(); wr(2'd3, 15'h29);
        ext[4] = 1'b1; step();                                // re-presented
        check(intr === 1'b1, "R7", int'(intr), 1);
        tag = "R4"; quiet(); ien = 1'b0; tmr = 3'b111; inta = 1'b1; step();
        check(intr === 1'b0, "R4", int'(intr), 0);
        ien = 1'b1;
        tag = "R9"; tmr = 3'b110; inta = 1'b1; step();
        check(itype === 8'h09, "R9", int'(itype), 8'h09);
        quiet(); wr(2'd3, 15'h09);
        tag = "R3"; wr(2'd0, 15'h0002);
        ext[0] = 1'b1; step();
        check(intr === 1'b0, "R3", int'(intr), 0);
        per[0] = 1'b1; inta = 1'b1; step();
        check(itype === 8'h23, "R3", int'(itype), 8'h23);
        quiet(); wr(2'd3, 15'h23); wr(2'd0, 15'h0000);
        tag = "R6"; per[2] = 1'b1; inta = 1'b1; step();       // ch5 in service
        per[5] = 1'b1; step();                                // ch5, ch8 held
        check(intr === 1'b0, "R6", int'(intr), 0);
        tmr[0] = 1'b1; inta = 1'b1; step();                   // ch0 preempts
        check(itype === 8'h08, "R6", int'(itype), 8'h08);
        tag = "R8"; quiet(); wr(2'd3, 15'h2A); wr(2'd3, 15'h77);
        per[5] = 1'b1; step();
        check(intr === 1'b0, "R8", int'(intr), 0);
        tag = "R7"; quiet(); wr(2'd3, 15'h08); wr(2'd3, 15'h25);
        per[5] = 1'b1; step();
        check(intr === 1'b1, "R7", int'(intr), 1);
        tag = "R10"; quiet(); wr(2'd2, 15'h1);
        ext[4] = 1'b1; step();
        check(intr === 1'b0, "R10", int'(intr), 0);
        dma = 2'b11; inta = 1'b1; step();
        check(itype === 8'h30, "R10", int'(itype), 8'h30);
        quiet(); wr(2'd3, 15'h31);                            // decodes to ch9
        dma = 2'b10; inta = 1'b1; step();
        check(itype === 8'h31, "R10", int'(itype), 8'h31);
        quiet(); wr(2'd3, 15'h30);
        tag = "R11"; wr(2'd1, 15'h7FFF & ~15'h0800);          // unmask pin 4 bit
        ext[4] = 1'b1; inta = 1'b1; step();
        check(itype === 8'h2E, "R11", int'(itype), 8'h2E);
        quiet(); wr(2'd3, 15'h2E);
        pio[3] = 1'b1; step();
        check(intr === 1'b0, "R11", int'(intr), 0);
        tag = "R12"; quiet(); ext[8] = 1'b1; inta = 1'b1; step();
        check(itype === 8'h22, "R12", int'(itype), 8'h22);
        quiet(); per[9] = 1'b1; wr(2'd3, 15'h22);
        inta = 1'b1; step();
        check(itype === 8'h2D, "R12", int'(itype), 8'h2D);
        quiet(); wr(2'd3, 15'h2D);

        // R2: random mix
        tag = "R2";
        for (int n = 0; n < 3000; n++) begin
            int r;
            ien = ($urandom % 8) != 0;
            tmr = 3'($urandom & $urandom & $urandom);
            dma = 2'($urandom & $urandom & $urandom);
            ext = 9'($urandom & $urandom & $urandom);
            pio = 8'($urandom & $urandom);
            per = 10'($urandom & $urandom & $urandom);
            inta = ($urandom % 3) == 0;
            r = int'($urandom % 16);
            if (r < 4) begin
                int c = int'($urandom % 15);
                if (m_is[c]) begin wr_en = 1'b1; wr_addr = 2'd3; wr_data = {7'd0, m_ty[c]}; end
            end else if (r == 4) begin
                wr_en = 1'b1; wr_addr = 2'd3; wr_data = 15'($urandom);
            end else if (r == 5) begin
                wr_en = 1'b1; wr_addr = 2'd0; wr_data = 15'($urandom & $urandom & $urandom);
            end else if (r == 6) begin
                wr_en = 1'b1; wr_addr = 2'd1; wr_data = 15'($urandom);
            end else if (r == 7) begin
                wr_en = 1'b1; wr_addr = 2'd2; wr_data = 15'($urandom);
            end
            step();
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual 0x1 expected 0x0");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule